// File: doc/BRIEF.md
# Prescaled Free-Running Counter with Coherent Byte Read

This block keeps a 16-bit up-counter that runs continuously once enabled and advances once every four bus clocks through a fixed 2-bit prescaler. Other timer functions take the full count from the `count` output. The counter wraps from 0xFFFF to 0x0000 and sets a sticky overflow flag on the wrap. A separate strobe clears the flag.

An 8-bit host reads the count one byte at a time. A high-byte read returns the upper byte and, in the same cycle, stores the matching lower byte in a snapshot register. The following low-byte read returns that snapshot, so the two bytes form one consistent 16-bit value even though the counter keeps moving between the two accesses. Reads are pure observations and never disturb the count or the flag.

Reset loads the counter with 0xFFFC. The counter then waits for `start_en`, which stands in for the end of the oscillator startup delay, before it counts. With the default widths the count sequence repeats every 262,144 bus clocks.

Top module: `prescaled_frc`

## Requirements
- R1: `count` is a 16-bit up-counter that only ever moves by +1 and wraps from 0xFFFF to 0x0000.
- R2: A synchronous active-high `rst` loads the counter with 0xFFFC and clears the prescaler, `ovf_flag`, `rd_data` and the snapshot. While `start_en` is low, `count` holds its value.
- R3: While `start_en` is high, `count` advances once every 4 clocks. After reset the first advance happens on the 4th enabled rising edge, and `count` never changes on two consecutive edges.
- R4: `ovf_flag` goes to 1 on the edge where `count` wraps from 0xFFFF to 0x0000, and stays set.
- R5: `ovf_clr` high at a rising edge clears `ovf_flag`. If a wrap happens on the same edge, the set wins and the flag stays 1. The flag never falls without `ovf_clr`.
- R6: A high-byte read (`rd_hi` high at an edge) makes `rd_data` equal bits 15:8 of `count` at that edge, and stores bits 7:0 from the same edge. The next low-byte read returns the stored byte and ends the read sequence.
- R7: Further high-byte reads before the low-byte read return the live upper byte but do not replace the stored low byte.
- R8: A low-byte read (`rd_lo` high) with no pending high-byte read returns bits 7:0 of the live `count` at that edge.
- R9: Reads of either byte, in any order and any number, leave `count` and `ovf_flag` unchanged.
- R10: When `rd_hi` and `rd_lo` are both high at one edge, the access is handled as a high-byte read only.
- R11: `rd_data` is registered and holds its value in cycles with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_en | input | 1 | Counting enable (end of startup delay) |
| rd_hi | input | 1 | High-byte read strobe |
| rd_lo | input | 1 | Low-byte read strobe |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| rd_data | output | 8 | Registered read data |
| ovf_flag | output | 1 | Sticky overflow flag |
| count | output | 16 | Live counter value for other timer functions |

## Verification
The hardest case to reach from the ports is a wrap that lands on the same edge as a flag clear. The counter starts near the top of its range, so the bench restarts it with `ovf_clr` held high and lets exactly sixteen enabled edges pass. That makes the wrap coincide with an active clear without waiting a full count period. A coherent read is only meaningful if the lower byte moves, and ideally the upper byte too, between the two byte reads. The stimulus therefore opens read sequences just before the wrap and leaves many prescaled steps before the low-byte read.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned FRC_CNT_W  = 16;
  localparam int unsigned FRC_BYTE_W = 8;
  localparam int unsigned FRC_PRE_W  = 2;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_HI   = 2'd1,
    ACC_LO   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/frc_prescale.sv
module frc_prescale #(
  parameter int unsigned PRE_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam logic [PRE_W-1:0] TERM = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (en) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign tick = en && (pre_q == TERM);
endmodule

// File: rtl/frc_count.sv
module frc_count #(
  parameter int unsigned CNT_W     = 16,
  parameter logic [CNT_W-1:0] INIT_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic wrap;
  assign wrap = tick && (count == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= INIT_VAL;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
    end else if (wrap) begin
      ovf_flag <= 1'b1;
    end else if (ovf_clr) begin
      ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/frc_rdview.sv
module frc_rdview
  import frc_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] hi_b, lo_b, snap_q;
  logic              held_q;
  acc_kind_e         acc;

  assign hi_b = count[CNT_W-1 -: BYTE_W];
  assign lo_b = count[BYTE_W-1:0];

  always_comb begin
    if (rd_hi)      acc = ACC_HI;
    else if (rd_lo) acc = ACC_LO;
    else            acc = ACC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      snap_q  <= '0;
      held_q  <= 1'b0;
    end else begin
      case (acc)
        ACC_HI: begin
          rd_data <= hi_b;
          if (!held_q) begin
            snap_q <= lo_b;
            held_q <= 1'b1;
          end
        end
        ACC_LO: begin
          rd_data <= held_q ? snap_q : lo_b;
          held_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prescaled_frc.sv
module prescaled_frc
  import frc_pkg::*;
#(
  parameter int unsigned CNT_W  = FRC_CNT_W,
  parameter int unsigned BYTE_W = FRC_BYTE_W,
  parameter int unsigned PRE_W  = FRC_PRE_W,
  parameter logic [CNT_W-1:0] INIT_VAL = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_en,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ovf_flag,
  output logic [CNT_W-1:0]  count
);
  logic tick;

  frc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .en  (start_en),
    .tick(tick)
  );

  frc_count #(.CNT_W(CNT_W), .INIT_VAL(INIT_VAL)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .ovf_clr (ovf_clr),
    .count   (count),
    .ovf_flag(ovf_flag)
  );

  frc_rdview #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_hi  (rd_hi),
    .rd_lo  (rd_lo),
    .count  (count),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/prescaled_frc_chk.sv
module prescaled_frc_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_en,
  input logic              rd_hi,
  input logic              rd_lo,
  input logic              ovf_clr,
  input logic [BYTE_W-1:0] rd_data,
  input logic              ovf_flag,
  input logic [CNT_W-1:0]  count
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  // R1
  step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (live && count != $past(count)) |-> count == $past(count) + 1'b1);

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (live && !start_en) |=> $stable(count));

  // R3
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (live && count != $past(count)) |=> $stable(count));

  // R4
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(count) == {CNT_W{1'b1}} && count == '0) |-> ovf_flag);

  // R5
  flag_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $fell(ovf_flag)) |-> $past(ovf_clr));

  // R9
  flag_rise_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $rose(ovf_flag)) |-> (count == '0 && $past(count) == {CNT_W{1'b1}}));

  // R11
  data_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (live && !rd_hi && !rd_lo) |=> $stable(rd_data));
endmodule

bind prescaled_frc prescaled_frc_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_en(start_en),
  .rd_hi   (rd_hi),
  .rd_lo   (rd_lo),
  .ovf_clr (ovf_clr),
  .rd_data (rd_data),
  .ovf_flag(ovf_flag),
  .count   (count)
);

// File: tb/prescaled_frc_tb.sv
module prescaled_frc_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_en = 1'b0;
  logic        rd_hi = 1'b0;
  logic        rd_lo = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [7:0]  rd_data;
  logic        ovf_flag;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  int unsigned n_en = 0;

  always #(CLK_P/2) clk = ~clk;

  prescaled_frc u_dut (
    .clk(clk), .rst(rst), .start_en(start_en), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .ovf_clr(ovf_clr), .rd_data(rd_data), .ovf_flag(ovf_flag), .count(count)
  );

  // reference: number of enabled edges since reset, one step per four
  always @(posedge clk) begin
    if (rst) n_en <= 0;
    else if (start_en) n_en <= n_en + 1;
  end

  function automatic logic [15:0] exp_cnt();
    logic [31:0] steps;
    steps = n_en >> 2;
    return 16'hFFFC + steps[15:0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start_en = 1'b0; rd_hi = 1'b0; rd_lo = 1'b0; ovf_clr = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_hi(output logic [15:0] seen);
    seen = exp_cnt();
    rd_hi = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0;
  endtask

  task automatic read_lo(output logic [15:0] seen);
    seen = exp_cnt();
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 reset count", count, 16'hFFFC);
    chk("R2 reset flag", {15'd0, ovf_flag}, 16'd0);
    chk("R2 reset rd_data", {8'd0, rd_data}, 16'd0);
    repeat (12) @(negedge clk);
    chk("R2 hold while disabled", count, 16'hFFFC);
  endtask

  task automatic t_prescale();
    do_reset();
    start_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 before 4th edge", count, 16'hFFFC);
    @(negedge clk);
    chk("R3 on 4th edge", count, 16'hFFFD);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R3 prescaled rate", count, exp_cnt());
    end
  endtask

  task automatic t_wrap();
    do_reset();
    start_en = 1'b1;
    repeat (15) @(negedge clk);
    chk("R1 top value", count, 16'hFFFF);
    chk("R4 flag before wrap", {15'd0, ovf_flag}, 16'd0);
    @(negedge clk);
    chk("R1 wrap to zero", count, 16'h0000);
    chk("R4 flag on wrap", {15'd0, ovf_flag}, 16'd1);
    repeat (5) @(negedge clk);
    chk("R4 flag sticky", {15'd0, ovf_flag}, 16'd1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R5 clear", {15'd0, ovf_flag}, 16'd0);
  endtask

  task automatic t_clr_prio();
    do_reset();
    start_en = 1'b1; ovf_clr = 1'b1;
    repeat (16) @(negedge clk);
    chk("R5 set beats clear", {15'd0, ovf_flag}, 16'd1);
    @(negedge clk);
    chk("R5 clear next edge", {15'd0, ovf_flag}, 16'd0);
    ovf_clr = 1'b0;
  endtask

  task automatic t_coherent();
    logic [15:0] e1, e2;
    do_reset();
    start_en = 1'b1;
    repeat (10) @(negedge clk);
    read_hi(e1);
    chk("R6 high byte", {8'd0, rd_data}, {8'd0, e1[15:8]});
    repeat (20) @(negedge clk);
    read_lo(e2);
    chk("R6 snapshot low byte", {8'd0, rd_data}, {8'd0, e1[7:0]});
    repeat (6) @(negedge clk);
    read_lo(e2);
    chk("R8 live low after sequence", {8'd0, rd_data}, {8'd0, e2[7:0]});
  endtask

  task automatic t_repeat_hi();
    logic [15:0] e1, e2, e3;
    do_reset();
    start_en = 1'b1;
    repeat (9) @(negedge clk);
    read_hi(e1);
    repeat (12) @(negedge clk);
    read_hi(e2);
    chk("R7 second high live", {8'd0, rd_data}, {8'd0, e2[15:8]});
    repeat (12) @(negedge clk);
    read_lo(e3);
    chk("R7 snapshot kept", {8'd0, rd_data}, {8'd0, e1[7:0]});
  endtask

  task automatic t_live_lo();
    logic [15:0] e;
    do_reset();
    start_en = 1'b1;
    repeat (7) @(negedge clk);
    read_lo(e);
    chk("R8 live low", {8'd0, rd_data}, {8'd0, e[7:0]});
    repeat (8) @(negedge clk);
    chk("R11 rd_data holds", {8'd0, rd_data}, {8'd0, e[7:0]});
  endtask

  task automatic t_noeffect();
    do_reset();
    start_en = 1'b1;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 48; i++) begin
      rd_hi = (i % 3) != 1;
      rd_lo = (i % 2) == 1;
      @(negedge clk);
      chk("R9 count undisturbed", count, exp_cnt());
      chk("R9 flag undisturbed", {15'd0, ovf_flag}, 16'd1);
    end
    rd_hi = 1'b0; rd_lo = 1'b0;
  endtask

  task automatic t_both();
    logic [15:0] e1, e2;
    do_reset();
    start_en = 1'b1;
    repeat (5) @(negedge clk);
    e1 = exp_cnt();
    rd_hi = 1'b1; rd_lo = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0; rd_lo = 1'b0;
    chk("R10 both strobes act as high", {8'd0, rd_data}, {8'd0, e1[15:8]});
    repeat (16) @(negedge clk);
    read_lo(e2);
    chk("R10 snapshot taken", {8'd0, rd_data}, {8'd0, e1[7:0]});
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_wrap();
    t_clr_prio();
    t_coherent();
    t_repeat_hi();
    t_live_lo();
    t_noeffect();
    t_both();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule